// File: doc/BRIEF.md
# Three-Wire Serial Word Memory

A slave memory that sits on a three-wire serial bus: a select input, a serial clock and a data line in each direction. It holds 2^ADDR_W words of DATA_W bits in a register array. The host raises select and shifts in an instruction one bit per rising clock edge. An instruction is a start bit, a two-bit opcode, an address and, for the two instructions that carry data, a data word. The block reads, writes, erases and fills the array. A write-enable latch guards every programming instruction.

A read produces one zero bit first. It then streams the addressed word MSB first and carries on through the following words without a new instruction. The address wraps at the top of the array. The stream stops only when select falls. After a programming instruction that was allowed to run, the output line reports busy (low) for a fixed number of clocks and then ready (high). The serial clock is the block's only clock, so it may stop for any length of time and the block keeps its state.

Top module: `mw_serial_mem`

## Requirements
- R1: With select high, zeros on the data input are skipped. An instruction starts at the first 1 sampled on a rising edge.
- R2: After the start bit come a 2-bit opcode and an ADDR_W-bit address, both MSB first. Opcode 10 reads, 01 writes and 11 erases one word. Opcode 00 takes its meaning from the top two address bits: 11 enables programming, 00 disables it, 10 erases all words and 01 writes all words.
- R3: On the rising edge that samples the last address bit of a read, the output goes to 0 (the lead bit). Each following rising edge puts out one bit of the addressed word, MSB first.
- R4: When a read has sent all DATA_W bits of a word, the next edge starts on the word at the next address, wrapping from the top address to 0. This goes on for as long as select stays high.
- R5: A write takes DATA_W data bits, MSB first, after the address and stores them in the addressed word. Write-all stores them in every word.
- R6: Erase sets the addressed word to all ones. Erase-all sets every word to all ones.
- R7: Reset clears the enable latch. While the latch is clear, write, write-all, erase and erase-all leave the array unchanged and the output stays low until select falls.
- R8: The disable instruction clears the enable latch, after which programming is locked again.
- R9: After an enabled programming instruction, the output is low for BUSY_CYCLES rising edges counted from the edge that completed it. From then on it is high until select falls.
- R10: When select is low the output is low. A rising edge with select low returns the parser to waiting for a start bit, and any unfinished instruction is dropped with no effect.
- R11: After reset every word reads as zero and the output is low.
- R12: If the serial clock stops partway through an instruction, the instruction completes correctly once the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sk_i | input | 1 | Serial clock; all state advances on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Select, active high |
| din_i | input | 1 | Serial instruction and data input |
| dout_o | output | 1 | Serial read data, or busy/ready after programming |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=16 and BUSY_CYCLES=3. A 16-word array lets one read stream cross the wrap point and cover every word within a few hundred clocks. It also lets write-all and erase-all be confirmed across the whole array. The short busy window keeps the busy-then-ready edge close to the completing bit, so its position is checked exactly. The opcode-00 sub-decode still uses the top two address bits of a 4-bit address.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_DATA, S_READ, S_BUSY, S_READY, S_HOLD
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // sub-codes carried in the top two address bits of OP_EXT
  localparam logic [1:0] EX_WDS   = 2'b00;
  localparam logic [1:0] EX_WRALL = 2'b01;
  localparam logic [1:0] EX_ERALL = 2'b10;
  localparam logic [1:0] EX_WEN   = 2'b11;
endpackage

// File: rtl/mw_sipo.sv
module mw_sipo #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= {q_q[W-2:0], din_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rd_words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;

    assign hit = we_i && (all_i || (waddr_i == ADDR_W'(i)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '0;
      else if (hit) word_q <= wdata_i;
    end

    assign rd_words[i] = word_q;
  end

  assign rdata_o = rd_words[raddr_i];
endmodule

// File: rtl/mw_stream.sv
module mw_stream #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              bit_o
);
  localparam int BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              bit_q;
  logic              word_end;

  assign word_end = (bcnt_q == BCNT_W'(DATA_W - 1));
  // start: fetch the requested word; otherwise prefetch the next one
  assign raddr_o  = start_i ? start_addr_i : addr_q + ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      addr_q <= '0;
      bcnt_q <= '0;
      bit_q  <= 1'b0;
    end else if (start_i) begin
      sr_q   <= rdata_i;
      addr_q <= start_addr_i;
      bcnt_q <= '0;
      bit_q  <= 1'b0;       // lead bit
    end else if (run_i) begin
      bit_q <= sr_q[DATA_W-1];
      if (word_end) begin
        addr_q <= raddr_o;
        sr_q   <= rdata_i;
        bcnt_q <= '0;
      end else begin
        sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
        bcnt_q <= bcnt_q + BCNT_W'(1);
      end
    end
  end

  assign bit_o = bit_q;

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && word_end) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
  import mw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 8
) (
  input  logic sk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic din_i,
  output logic dout_o
);
  localparam int CMD_W   = 2 + ADDR_W;
  localparam int CNT_MAX = (CMD_W > DATA_W) ?
                           ((CMD_W > BUSY_CYCLES) ? CMD_W : BUSY_CYCLES) :
                           ((DATA_W > BUSY_CYCLES) ? DATA_W : BUSY_CYCLES);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  mw_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wen_q;

  logic [CMD_W-1:0]  cmd_q, cmd_next;
  logic [DATA_W-2:0] data_q;
  logic [DATA_W-1:0] data_next;
  logic [1:0]        op_w, ext_w;
  logic [ADDR_W-1:0] addr_w;
  logic              cmd_last, data_last;

  logic              prog_req, mem_we, wr_all, rd_start, rd_run;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              str_bit;

  mw_sipo #(.W(CMD_W)) u_cmd_sr (
    .clk_i (sk_i),
    .rst_ni(rst_ni),
    .en_i  (cs_i && state_q == S_CMD),
    .din_i (din_i),
    .q_o   (cmd_q)
  );

  mw_sipo #(.W(DATA_W - 1)) u_data_sr (
    .clk_i (sk_i),
    .rst_ni(rst_ni),
    .en_i  (cs_i && state_q == S_DATA),
    .din_i (din_i),
    .q_o   (data_q)
  );

  // decode sees the bit arriving on this edge
  assign cmd_next  = {cmd_q[CMD_W-2:0], din_i};
  assign data_next = {data_q, din_i};
  assign op_w      = cmd_next[CMD_W-1 -: 2];
  assign addr_w    = cmd_next[ADDR_W-1:0];
  assign ext_w     = addr_w[ADDR_W-1 -: 2];
  assign cmd_last  = cs_i && state_q == S_CMD  && cnt_q == CNT_W'(CMD_W - 1);
  assign data_last = cs_i && state_q == S_DATA && cnt_q == CNT_W'(DATA_W - 1);

  always_comb begin
    prog_req = 1'b0;
    wr_all   = 1'b0;
    wr_addr  = addr_w;
    wr_data  = '1;
    rd_start = 1'b0;
    if (cmd_last) begin
      unique case (op_w)
        OP_READ:  rd_start = 1'b1;
        OP_ERASE: prog_req = 1'b1;
        OP_EXT: if (ext_w == EX_ERALL) begin
          prog_req = 1'b1;
          wr_all   = 1'b1;
        end
        default: ;
      endcase
    end
    if (data_last) begin
      prog_req = 1'b1;
      wr_all   = (cmd_q[CMD_W-1 -: 2] == OP_EXT);
      wr_addr  = cmd_q[ADDR_W-1:0];
      wr_data  = data_next;
    end
  end

  assign mem_we = prog_req && wen_q;
  assign rd_run = cs_i && state_q == S_READ;

  mw_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i  (sk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .all_i  (wr_all),
    .waddr_i(wr_addr),
    .wdata_i(wr_data),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  mw_stream #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stream (
    .clk_i       (sk_i),
    .rst_ni      (rst_ni),
    .start_i     (rd_start),
    .run_i       (rd_run),
    .start_addr_i(addr_w),
    .rdata_i     (rd_data),
    .raddr_o     (rd_addr),
    .bit_o       (str_bit)
  );

  always_ff @(posedge sk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wen_q   <= 1'b0;
    end else if (!cs_i) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (din_i) begin
          state_q <= S_CMD;
          cnt_q   <= '0;
        end
        S_CMD: begin
          if (cmd_last) begin
            cnt_q <= '0;
            unique case (op_w)
              OP_READ:  state_q <= S_READ;
              OP_WRITE: state_q <= S_DATA;
              OP_ERASE: state_q <= wen_q ? S_BUSY : S_HOLD;
              default: begin
                unique case (ext_w)
                  EX_WEN:   begin wen_q <= 1'b1; state_q <= S_HOLD; end
                  EX_WDS:   begin wen_q <= 1'b0; state_q <= S_HOLD; end
                  EX_ERALL: state_q <= wen_q ? S_BUSY : S_HOLD;
                  default:  state_q <= S_DATA;
                endcase
              end
            endcase
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_DATA: begin
          if (data_last) begin
            cnt_q   <= '0;
            state_q <= wen_q ? S_BUSY : S_HOLD;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_BUSY: begin
          if (cnt_q == CNT_W'(BUSY_CYCLES - 1)) state_q <= S_READY;
          else                                  cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: ;  // S_READ, S_READY, S_HOLD wait for select to fall
      endcase
    end
  end

  assign dout_o = cs_i && ((state_q == S_READ && str_bit) || state_q == S_READY);

  p_lead_zero_r3: assert property (@(posedge sk_i) disable iff (!rst_ni)
    (cmd_last && op_w == OP_READ) |=> !dout_o);

  p_ready_after_busy_r9: assert property (@(posedge sk_i) disable iff (!rst_ni)
    (cs_i && state_q == S_BUSY && cnt_q == CNT_W'(BUSY_CYCLES - 1)) |=> (dout_o || !cs_i));

  p_locked_quiet_r7: assert property (@(posedge sk_i) disable iff (!rst_ni)
    (prog_req && !wen_q) |=> !dout_o);

  p_disable_clears_r8: assert property (@(posedge sk_i) disable iff (!rst_ni)
    (cmd_last && op_w == OP_EXT && ext_w == EX_WDS) |=> !wen_q);

  p_deselect_idle_r10: assert property (@(posedge sk_i) disable iff (!rst_ni)
    !cs_i |=> (state_q == S_IDLE));
endmodule

// File: tb/mw_serial_mem_test.sv
`timescale 1ns/1ps
module mw_serial_mem_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int BC = 3;
  localparam int NW = 1 << AW;

  logic sk = 1'b0;
  logic run_clk = 1'b1;
  logic rst_ni = 1'b0;
  logic cs = 1'b0;
  logic din = 1'b0;
  logic dout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem_m [NW];
  bit wen_m = 1'b0;

  always #2 sk = run_clk ? ~sk : sk;

  mw_serial_mem #(.DATA_W(DW), .ADDR_W(AW), .BUSY_CYCLES(BC)) uut (
    .sk_i  (sk),
    .rst_ni(rst_ni),
    .cs_i  (cs),
    .din_i (din),
    .dout_o(dout)
  );

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic step(bit c, bit d, bit exp, string req);
    cs = c;
    din = d;
    @(posedge sk);
    @(negedge sk);
    check(req, dout, exp);
  endtask

  task automatic deselect();
    step(1'b0, 1'b0, 1'b0, "R10");
  endtask

  task automatic send_hdr(bit [1:0] op, bit [AW-1:0] a, int lead, string req);
    for (int i = 0; i < lead; i++) step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, req);
    for (int i = 1; i >= 0; i--) step(1'b1, op[i], 1'b0, req);
    for (int i = AW - 1; i >= 0; i--) step(1'b1, a[i], 1'b0, req);  // last one: lead zero on reads
  endtask

  task automatic busy_tail(string lock_req);
    for (int k = 1; k <= BC + 2; k++) begin
      if (wen_m) step(1'b1, 1'b0, (k >= BC), "R9");
      else       step(1'b1, 1'b0, 1'b0, lock_req);
    end
    deselect();
  endtask

  task automatic read_run(bit [AW-1:0] a, int nwords);
    send_hdr(2'b10, a, 0, "R3");
    for (int w = 0; w < nwords; w++)
      for (int b = DW - 1; b >= 0; b--)
        step(1'b1, 1'b0, mem_m[(int'(a) + w) % NW][b], (w == 0) ? "R3" : "R4");
    deselect();
  endtask

  task automatic do_write(bit [AW-1:0] a, logic [DW-1:0] d, string lock_req);
    send_hdr(2'b01, a, 0, "R2");
    for (int b = DW - 1; b >= 0; b--) step(1'b1, d[b], 1'b0, "R5");
    if (wen_m) mem_m[a] = d;
    busy_tail(lock_req);
  endtask

  task automatic do_wrall(logic [DW-1:0] d);
    send_hdr(2'b00, {2'b01, {(AW-2){1'b0}}}, 0, "R2");
    for (int b = DW - 1; b >= 0; b--) step(1'b1, d[b], 1'b0, "R5");
    if (wen_m) for (int i = 0; i < NW; i++) mem_m[i] = d;
    busy_tail("R7");
  endtask

  task automatic do_erase(bit [AW-1:0] a, string lock_req);
    send_hdr(2'b11, a, 0, "R6");
    if (wen_m) mem_m[a] = '1;
    busy_tail(lock_req);
  endtask

  task automatic do_eral();
    send_hdr(2'b00, {2'b10, {(AW-2){1'b0}}}, 0, "R6");
    if (wen_m) for (int i = 0; i < NW; i++) mem_m[i] = '1;
    busy_tail("R7");
  endtask

  task automatic do_ext(bit [1:0] sub, int lead, string req);
    send_hdr(2'b00, {sub, {(AW-2){1'b0}}}, lead, req);
    step(1'b1, 1'b0, 1'b0, req);  // no busy after enable/disable
    deselect();
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mem_m[i] = '0;
    repeat (3) @(negedge sk);
    check("R11", dout, 1'b0);
    rst_ni = 1'b1;
    @(negedge sk);
    check("R11", dout, 1'b0);
    read_run(0, 2);                        // R11: array starts at zero

    do_write(3, 16'h1234, "R7");           // locked after reset
    read_run(3, 1);

    do_ext(2'b11, 3, "R2");                // enable, preceded by skipped zeros (R1)
    wen_m = 1'b1;
    do_wrall(16'hA5C3);
    read_run(14, 3);                       // R4 wrap 14,15,0

    do_write(5, 16'h1234, "R7");
    do_write(15, 16'h8001, "R7");
    do_erase(2, "R7");
    read_run(15, 4);                       // 15,0,1,2

    // R12: clock halted mid-data
    send_hdr(2'b01, 7, 0, "R12");
    for (int b = DW - 1; b >= 8; b--) step(1'b1, 16'h0F0F >> b, 1'b0, "R12");
    run_clk = 1'b0;
    #100;
    check("R12", dout, 1'b0);
    run_clk = 1'b1;
    for (int b = 7; b >= 0; b--) step(1'b1, 16'h0F0F >> b, 1'b0, "R12");
    mem_m[7] = 16'h0F0F;
    busy_tail("R7");
    read_run(7, 1);

    // R10: aborted write leaves word alone
    send_hdr(2'b01, 9, 0, "R10");
    for (int b = DW - 1; b >= 11; b--) step(1'b1, 1'b0, 1'b0, "R10");
    deselect();
    read_run(9, 1);

    do_ext(2'b00, 0, "R8");                // disable
    wen_m = 1'b0;
    do_erase(5, "R8");
    do_write(6, 16'hFFFF, "R8");
    read_run(5, 2);

    do_ext(2'b11, 0, "R2");
    wen_m = 1'b1;
    do_eral();
    read_run(0, NW + 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule